// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts down on its own slow, low-power clock, apart from the system clock that drives its register bus. Software starts it, refreshes it and reconfigures it by writing 16-bit key codes and configuration values over a small register bus. If software stops refreshing it, the 12-bit counter runs out and the block raises a one-cycle reset request in the slow clock domain, then reloads and keeps running.

The divide ratio and the reload value sit behind a key: a configuration write is taken only while the unlock key is the most recent key written. Each accepted configuration write, and each start or refresh command, is carried into the slow domain by a toggle handshake. A busy flag per configuration register stays set in the status register until the slow side has taken the new value, and a write to a busy register is dropped. A strap input makes the watchdog run from reset with no software action.

Top module: `wdt_top`

## Requirements
- R1: After reset the divide code reads 0 (divide by 4), the reload value reads 0xFFF, the status reads 0, the key address reads 0 and no reset request is raised.
- R2: Address 0 is the write-only key register (reads 0). Key 0xCCCC starts the counter, 0x5555 unlocks configuration and 0xAAAA refreshes; a key write of any value other than 0x5555 locks configuration again.
- R3: The divide code (address 1, bits 2:0) and the reload value (address 2, bits 11:0) change only while configuration is unlocked; otherwise the write is ignored.
- R4: The reload value is masked to its low 12 bits; upper data bits are dropped.
- R5: Status (address 3) bit 0 is the divide-code busy flag and bit 1 the reload busy flag; each is set from the cycle after an accepted write until the value reaches the slow domain, and clears within 20 system clock cycles when the slow clock runs at a third of the system clock rate.
- R6: A write to the divide code or the reload value while that register's busy flag is set is ignored.
- R7: Divide code k selects a ratio of 2^(k+2) for k = 0..6 and 256 for k = 7; while running with no refresh, consecutive reset requests are (reload+1) times the ratio slow cycles apart.
- R8: With the strap low, the counter stays idle and raises no request, even on a refresh key, until the start key is written.
- R9: With the strap high, the counter runs from reset at 0xFFF with divide by 4 and raises its first request 16385 slow cycles (within one) after reset release.
- R10: A refresh reloads the counter and restarts the divider; refreshes spaced closer than the timeout keep the request from being raised, and the request follows the last refresh by one timeout plus the crossing delay.
- R11: Once running the counter cannot be stopped by any key; each request lasts exactly one slow cycle and the counter then reloads and continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (bus) clock |
| rst_n | input | 1 | Asynchronous active-low reset of both domains |
| slow_clk | input | 1 | Slow watchdog clock |
| auto_en | input | 1 | Strap: run from reset without a start key |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current address |
| wdt_rst_req | output | 1 | One-slow-cycle reset request |

## Verification
The assertions watch, on every cycle, that locked or busy configuration writes leave the stored values unchanged, that any non-unlock key drops the unlock, that the counter steps down by one per divider tick and reloads with a one-cycle request at zero, that a started counter never stops and an idle one never requests, and that data in flight across the clock boundary holds still. Only the bench scenarios can show the end-to-end timeout lengths for each divide code, the start-up delay under the strap, the effect of refresh spacing and the bound on busy time, since those span the crossing and thousands of slow cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam int KEY_W = 16;
   localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
   localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
   localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

   typedef enum logic [1:0] {
      A_KEY  = 2'd0,
      A_DIV  = 2'd1,
      A_RLD  = 2'd2,
      A_STAT = 2'd3
   } wdt_addr_e;

   // event bits carried by the key crossing
   localparam int EV_START   = 1;
   localparam int EV_REFRESH = 0;
endpackage

// File: rtl/wdt_xfer.sv
// Toggle handshake carrying one value from the bus clock into the slow clock.
module wdt_xfer #(
   parameter int          DW      = 8,
   parameter int          SYNC    = 2,
   parameter logic [DW-1:0] RST_VAL = '0
) (
   input  logic          b_clk,
   input  logic          s_clk,
   input  logic          rst_n,
   input  logic          send,
   input  logic [DW-1:0] send_data,
   output logic          busy,
   output logic [DW-1:0] s_data,
   output logic          s_strobe
);
   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("wdt_xfer: SYNC must be at least 2");
      end
      if (DW < 1) begin : g_bad_dw
         $error("wdt_xfer: DW must be at least 1");
      end
   endgenerate

   logic            req_tog;
   logic [DW-1:0]   hold;
   logic [SYNC-1:0] s_sync;
   logic [SYNC-1:0] b_sync;
   logic            s_seen;
   logic            s_edge;

   // bus side: flip request, capture data
   always_ff @(posedge b_clk or negedge rst_n) begin
      if (!rst_n) begin
         req_tog <= 1'b0;
         hold    <= RST_VAL;
      end else if (send && !busy) begin
         req_tog <= ~req_tog;
         hold    <= send_data;
      end
   end

   // slow side: synchronise request, detect change, capture
   assign s_edge = s_sync[SYNC-1] ^ s_seen;

   always_ff @(posedge s_clk or negedge rst_n) begin
      if (!rst_n) begin
         s_sync   <= '0;
         s_seen   <= 1'b0;
         s_strobe <= 1'b0;
         s_data   <= RST_VAL;
      end else begin
         s_sync   <= {s_sync[SYNC-2:0], req_tog};
         s_seen   <= s_sync[SYNC-1];
         s_strobe <= s_edge;
         if (s_edge) s_data <= hold;
      end
   end

   // acknowledge back into the bus domain
   always_ff @(posedge b_clk or negedge rst_n) begin
      if (!rst_n) b_sync <= '0;
      else        b_sync <= {b_sync[SYNC-2:0], s_seen};
   end

   assign busy = req_tog ^ b_sync[SYNC-1];

   // R6: captured data may not move while the crossing is open
   assert_hold_stable_R6: assert property (@(posedge b_clk) disable iff (!rst_n)
      busy |=> $stable(hold));
   // R5: each accepted value produces a single slow-side strobe
   assert_strobe_single_R5: assert property (@(posedge s_clk) disable iff (!rst_n)
      s_strobe |=> !s_strobe);
endmodule

// File: rtl/wdt_regs.sv
// Bus-domain register file: key decode, write protection, readback.
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 12,
   parameter int PRE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy_div,
   input  logic              busy_rld,
   input  logic              busy_key,
   output logic              div_send,
   output logic [PRE_W-1:0]  div_wdata,
   output logic              rld_send,
   output logic [CNT_W-1:0]  rld_wdata,
   output logic              key_send,
   output logic [1:0]        key_ev,
   output logic [DATA_W-1:0] rdata
);
   generate
      if (DATA_W < KEY_W) begin : g_bad_data
         $error("wdt_regs: DATA_W must hold a key");
      end
      if (CNT_W > DATA_W || PRE_W > DATA_W) begin : g_bad_fields
         $error("wdt_regs: fields wider than the bus");
      end
   endgenerate

   logic             unlocked;
   logic [PRE_W-1:0] div_q;
   logic [CNT_W-1:0] rld_q;
   logic             wr_key, wr_div, wr_rld;
   logic             is_start, is_refresh;

   assign wr_key     = wr_en && (addr == A_KEY);
   assign wr_div     = wr_en && (addr == A_DIV);
   assign wr_rld     = wr_en && (addr == A_RLD);
   assign is_start   = (wdata[KEY_W-1:0] == KEY_START);
   assign is_refresh = (wdata[KEY_W-1:0] == KEY_REFRESH);

   assign div_wdata = wdata[PRE_W-1:0];
   assign rld_wdata = wdata[CNT_W-1:0];
   assign div_send  = wr_div && unlocked && !busy_div;
   assign rld_send  = wr_rld && unlocked && !busy_rld;
   assign key_send  = wr_key && (is_start || is_refresh) && !busy_key;
   assign key_ev    = {is_start, is_refresh};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         div_q    <= '0;
         rld_q    <= '1;
      end else begin
         if (wr_key)   unlocked <= (wdata[KEY_W-1:0] == KEY_UNLOCK);
         if (div_send) div_q    <= div_wdata;
         if (rld_send) rld_q    <= rld_wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (wdt_addr_e'(addr))
         A_DIV:   rdata[PRE_W-1:0] = div_q;
         A_RLD:   rdata[CNT_W-1:0] = rld_q;
         A_STAT:  rdata[1:0]       = {busy_rld, busy_div};
         default: rdata            = '0;
      endcase
   end

   // R3: locked writes leave the configuration untouched
   assert_locked_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div && !unlocked) |=> $stable(div_q));
   assert_locked_rld_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rld && !unlocked) |=> $stable(rld_q));
   // R6: busy registers drop writes
   assert_busy_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_div && busy_div) |=> $stable(div_q));
   assert_busy_rld_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_rld && busy_rld) |=> $stable(rld_q));
   // R2: any other key relocks
   assert_relock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_key && wdata[KEY_W-1:0] != KEY_UNLOCK) |=> !unlocked);
endmodule

// File: rtl/wdt_count.sv
// Slow-domain divider and 12-bit down counter.
module wdt_count #(
   parameter int CNT_W     = 12,
   parameter int PRE_W     = 3,
   parameter int MIN_SHIFT = 2,
   parameter int MAX_SHIFT = 8
) (
   input  logic             s_clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic [PRE_W-1:0] div_code,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             ev_strobe,
   input  logic             ev_start,
   input  logic             ev_refresh,
   output logic             rst_req
);
   localparam int DIV_W = MAX_SHIFT;

   generate
      if (MIN_SHIFT < 1 || MAX_SHIFT < MIN_SHIFT) begin : g_bad_shift
         $error("wdt_count: shift range is empty");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wdt_count: CNT_W must be positive");
      end
   endgenerate

   logic             running;
   logic [CNT_W-1:0] cnt;
   logic [DIV_W-1:0] pre_cnt;
   logic [DIV_W-1:0] limit;
   logic             tick;
   logic             do_start, do_refresh;

   // ratio 2^(code+MIN_SHIFT), clipped at 2^MAX_SHIFT
   always_comb begin
      int sh;
      sh = int'(div_code) + MIN_SHIFT;
      if (sh > MAX_SHIFT) sh = MAX_SHIFT;
      limit = {DIV_W{1'b1}} >> (MAX_SHIFT - sh);
   end

   assign tick       = running && (pre_cnt >= limit);
   assign do_start   = ev_strobe && ev_start && !running;
   assign do_refresh = ev_strobe && ev_refresh && running;

   always_ff @(posedge s_clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '1;
         pre_cnt <= '0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (auto_en && !running) begin
            running <= 1'b1;
            pre_cnt <= '0;
         end else if (do_start) begin
            running <= 1'b1;
            cnt     <= rld_val;
            pre_cnt <= '0;
         end else if (do_refresh) begin
            cnt     <= rld_val;
            pre_cnt <= '0;
         end else if (tick) begin
            pre_cnt <= '0;
            if (cnt == '0) begin
               cnt     <= rld_val;
               rst_req <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end else if (running) begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

   // R11: a started counter keeps running
   assert_never_stop_R11: assert property (@(posedge s_clk) disable iff (!rst_n)
      running |=> running);
   // R11: request is a single slow cycle
   assert_one_cycle_R11: assert property (@(posedge s_clk) disable iff (!rst_n)
      rst_req |=> !rst_req);
   // R8: an idle counter raises nothing
   assert_idle_quiet_R8: assert property (@(posedge s_clk) disable iff (!rst_n)
      !running |=> !rst_req);
   // R7: each tick steps the counter down by one
   assert_step_R7: assert property (@(posedge s_clk) disable iff (!rst_n)
      (tick && cnt != '0 && !do_refresh) |=> (cnt == $past(cnt) - 1'b1));
   // R11: reaching zero requests reset and reloads
   assert_wrap_R11: assert property (@(posedge s_clk) disable iff (!rst_n)
      (tick && cnt == '0 && !do_refresh) |=> (rst_req && cnt == $past(rld_val)));
   // R10: refresh reloads the counter
   assert_refresh_R10: assert property (@(posedge s_clk) disable iff (!rst_n)
      do_refresh |=> (cnt == $past(rld_val) && !rst_req));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
   import wdt_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 12,
   parameter int PRE_W  = 3,
   parameter int SYNC   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_clk,
   input  logic              auto_en,
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              wdt_rst_req
);
   logic             busy_div, busy_rld, busy_key;
   logic             div_send, rld_send, key_send;
   logic [PRE_W-1:0] div_wdata, div_s;
   logic [CNT_W-1:0] rld_wdata, rld_s;
   logic [1:0]       key_ev, key_s;
   logic             div_stb, rld_stb, key_stb;

   wdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .busy_div(busy_div), .busy_rld(busy_rld), .busy_key(busy_key),
      .div_send(div_send), .div_wdata(div_wdata),
      .rld_send(rld_send), .rld_wdata(rld_wdata),
      .key_send(key_send), .key_ev(key_ev), .rdata(rdata));

   wdt_xfer #(.DW(PRE_W), .SYNC(SYNC), .RST_VAL('0)) u_xdiv (
      .b_clk(clk), .s_clk(slow_clk), .rst_n(rst_n),
      .send(div_send), .send_data(div_wdata), .busy(busy_div),
      .s_data(div_s), .s_strobe(div_stb));

   wdt_xfer #(.DW(CNT_W), .SYNC(SYNC), .RST_VAL('1)) u_xrld (
      .b_clk(clk), .s_clk(slow_clk), .rst_n(rst_n),
      .send(rld_send), .send_data(rld_wdata), .busy(busy_rld),
      .s_data(rld_s), .s_strobe(rld_stb));

   wdt_xfer #(.DW(2), .SYNC(SYNC), .RST_VAL('0)) u_xkey (
      .b_clk(clk), .s_clk(slow_clk), .rst_n(rst_n),
      .send(key_send), .send_data(key_ev), .busy(busy_key),
      .s_data(key_s), .s_strobe(key_stb));

   wdt_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
      .s_clk(slow_clk), .rst_n(rst_n), .auto_en(auto_en),
      .div_code(div_s), .rld_val(rld_s),
      .ev_strobe(key_stb), .ev_start(key_s[EV_START]), .ev_refresh(key_s[EV_REFRESH]),
      .rst_req(wdt_rst_req));

   // R5: configuration strobes only follow an open crossing
   assert_div_stb_R5: assert property (@(posedge slow_clk) disable iff (!rst_n)
      div_stb |-> $past(div_stb) == 1'b0);
   assert_rld_stb_R5: assert property (@(posedge slow_clk) disable iff (!rst_n)
      rld_stb |-> $past(rld_stb) == 1'b0);
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
   localparam int CLK_PERIOD  = 10;
   localparam int SLOW_PERIOD = 30;

   logic        clk = 0, slow_clk = 0, rst_n = 0, auto_en = 0;
   logic        wr_en = 0;
   logic [1:0]  addr = 0;
   logic [15:0] wdata = 0;
   logic [15:0] rdata;
   logic        wdt_rst_req;

   int nvec = 0, nbad = 0;
   int sedge = 0, pulse_cnt = 0, last_pulse = 0;
   bit have_last = 0, prev_req = 0;
   int exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always #(SLOW_PERIOD/2) slow_clk = ~slow_clk;

   wdt_top dut (.clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .auto_en(auto_en),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .wdt_rst_req(wdt_rst_req));

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
      end
   endtask

   always @(posedge slow_clk or negedge rst_n)
      if (!rst_n) sedge <= 0; else sedge <= sedge + 1;

   // monitor: interval scoreboard
   always @(negedge slow_clk) begin
      if (!rst_n) begin
         have_last = 0; prev_req = 0;
      end else begin
         if (wdt_rst_req) begin
            check(prev_req == 0, "R11 request lasts one slow cycle", prev_req, 0);
            pulse_cnt++;
            if (have_last && exp_q.size() > 0) begin
               int e;
               e = exp_q.pop_front();
               check(sedge - last_pulse == e, "R7 request interval", sedge - last_pulse, e);
            end
            last_pulse = sedge;
            have_last  = 1;
         end
         prev_req = wdt_rst_req;
      end
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk); wr_en = 1; addr = a; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] v);
      @(negedge clk); addr = a; #1 v = rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [15:0] s;
      cyc = 0;
      rd(2'd3, s);
      while (s[1:0] != 0 && cyc < 1000) begin cyc++; rd(2'd3, s); end
   endtask

   task automatic wait_pulse();
      int c;
      c = pulse_cnt;
      while (pulse_cnt == c) @(negedge clk);
   endtask

   task automatic drain();
      while (exp_q.size() > 0) @(negedge clk);
   endtask

   task automatic do_reset(input bit ae);
      rst_n = 0; auto_en = ae; exp_q.delete();
      repeat (4) @(negedge slow_clk);
      rst_n = 1;
   endtask

   task automatic config_and_score(input int code, input int rld, input int n);
      int c, ratio;
      wr(2'd0, 16'h5555); wr(2'd1, 16'(code));
      wr(2'd0, 16'h5555); wr(2'd2, 16'(rld));
      wait_idle(c);
      ratio = (code >= 6) ? 256 : (4 << code);
      wait_pulse();
      wait_pulse();
      for (int i = 0; i < n; i++) exp_q.push_back((rld + 1) * ratio);
      drain();
   endtask

   initial begin
      logic [15:0] v;
      int c, pc, s0;
      // ---------- strap low ----------
      do_reset(0);
      rd(2'd1, v); check(v == 0, "R1 reset divide code", v, 0);
      rd(2'd2, v); check(v == 16'hFFF, "R1 reset reload", v, 16'hFFF);
      rd(2'd3, v); check(v == 0, "R1 reset status", v, 0);
      rd(2'd0, v); check(v == 0, "R2 key reads zero", v, 0);
      check(wdt_rst_req == 0, "R1 no request after reset", wdt_rst_req, 0);

      wr(2'd1, 16'd2); rd(2'd1, v); check(v == 0, "R3 locked divide write ignored", v, 0);
      wr(2'd2, 16'd5); rd(2'd2, v); check(v == 16'hFFF, "R3 locked reload write ignored", v, 16'hFFF);

      wr(2'd0, 16'h5555); wr(2'd1, 16'd1);
      rd(2'd3, v); check(v[0] == 1, "R5 divide busy set", v[0], 1);
      wr(2'd1, 16'd5);
      wait_idle(c); check(c > 0 && c <= 20, "R5 divide busy clears in time", c, 20);
      rd(2'd1, v); check(v == 1, "R6 busy divide write ignored", v, 1);

      wr(2'd2, 16'hF009);
      rd(2'd3, v); check(v[1] == 1, "R5 reload busy set", v[1], 1);
      wr(2'd2, 16'h00AB);
      wait_idle(c); check(c > 0 && c <= 20, "R5 reload busy clears in time", c, 20);
      rd(2'd2, v); check(v == 16'h009, "R4 reload masked / R6 busy ignored", v, 16'h009);

      wr(2'd0, 16'h1234); wr(2'd1, 16'd3);
      rd(2'd1, v); check(v == 1, "R2 other key relocks", v, 1);

      wr(2'd0, 16'hAAAA);
      repeat (300) @(negedge slow_clk);
      check(pulse_cnt == 0, "R8 idle until start key", pulse_cnt, 0);

      wr(2'd0, 16'hCCCC);
      wait_pulse();
      for (int i = 0; i < 3; i++) exp_q.push_back(80);
      drain();

      config_and_score(0, 3, 3);
      config_and_score(6, 1, 2);
      config_and_score(7, 0, 2);
      config_and_score(2, 4, 2);

      // refresh keeps request away
      wr(2'd0, 16'h5555); wr(2'd1, 16'd0);
      wr(2'd0, 16'h5555); wr(2'd2, 16'd49);
      wait_idle(c);
      wait_pulse();
      pc = pulse_cnt;
      s0 = 0;
      for (int i = 0; i < 10; i++) begin
         wr(2'd0, 16'hAAAA);
         s0 = sedge;
         repeat (60) @(negedge slow_clk);
      end
      check(pulse_cnt == pc, "R10 refresh prevents request", pulse_cnt, pc);
      wait_pulse();
      check(last_pulse - s0 >= 200 && last_pulse - s0 <= 210, "R10 request after last refresh",
            last_pulse - s0, 200);

      // cannot be stopped
      wr(2'd0, 16'h0000); wr(2'd0, 16'h5555); wr(2'd0, 16'hCCCC);
      wait_pulse();
      for (int i = 0; i < 2; i++) exp_q.push_back(200);
      drain();
      check(pulse_cnt >= pc + 3, "R11 keeps running after keys", pulse_cnt, pc + 3);

      // ---------- strap high ----------
      do_reset(1);
      rd(2'd2, v); check(v == 16'hFFF, "R1 reset reload (strap)", v, 16'hFFF);
      wait_pulse();
      check(last_pulse >= 16384 && last_pulse <= 16386, "R9 first strap timeout",
            last_pulse, 16385);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      nvec++; nbad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule